// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block sets how many bus clock cycles each CPU bus access lasts and then carries that access through to the end. At acceptance it samples an area code, a chip-select index and a bus-mode flag. It picks a cycle count from a two-level policy: one global wait bit takes precedence over four per-chip-select fast bits. Register space always takes two cycles, and multiplexed external accesses always take three. For external accesses, a ready input can stretch the access beyond its computed length.

The control bits live in three byte-wide registers inside the register area. They are written by an accepted write access to that area. The global wait bit is guarded: it only changes if the unlock bit was already set. The CPU sees a busy level and a one-cycle done pulse.

States: ST_IDLE waits for a request. ST_RUN counts down the computed cycles. ST_STRETCH holds an external access while ready is low. Transitions:
- ST_IDLE→ST_RUN when a request is accepted.
- ST_RUN→ST_RUN while cycles remain.
- ST_RUN→ST_IDLE on the last cycle when the access is not external or ready is high.
- ST_RUN→ST_STRETCH on the last cycle of an external access with ready low.
- ST_STRETCH→ST_IDLE when ready is high.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, busy and done are 0, the global wait bit is 0 and all four chip-select fast bits are 0. As a result, an internal-memory access takes 1 cycle and a separate-bus external access takes 2 cycles.
- R2: An access with area code 0 (register area) takes exactly 2 cycles, whatever the control bits hold.
- R3: An access with area code 1 (internal ROM/RAM) takes 1 cycle when the global wait bit is 0 and 2 cycles when it is 1.
- R4: An access with area code 2 (display RAM) always takes 2 cycles.
- R5: An access with area code 3 and mux_bus=0 takes 2 cycles when the global wait bit is 1. When the global wait bit is 0, it takes 1 cycle if the fast bit of its chip select is 1, otherwise 2 cycles.
- R6: An access with area code 3 and mux_bus=1 always takes 3 cycles, whatever the fast bit holds.
- R7: An accepted write (we=1) with area code 0 updates the control registers:
  - address 0x000A, bit 1 is the unlock bit;
  - address 0x0008, bits 4..7 are the fast bits of chip selects 0..3;
  - address 0x0005, bit 7 is the global wait bit.
- R8: A write to address 0x0005 while the unlock bit is 0 leaves the global wait bit unchanged.
- R9: In the last computed cycle of an external access, and in every cycle after it, the access completes only if rdy is 1. Each cycle with rdy at 0 adds one cycle. rdy has no effect on other areas.
- R10: busy is 1 from the cycle after acceptance through the final cycle. done is 1 for exactly that final cycle, and busy falls in the next cycle.
- R11: A request raised while busy is 1 is ignored. It starts no access and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, accepted when busy is 0 |
| addr | input | ADDR_W | Access address, used for register writes |
| we | input | 1 | Write strobe for the access |
| wdata | input | 8 | Write data byte for register writes |
| area | input | 2 | Area code: 0 register, 1 internal, 2 display RAM, 3 external |
| cs_idx | input | 2 | Chip-select index of an external access |
| mux_bus | input | 1 | 1 when the external access uses the multiplexed bus |
| rdy | input | 1 | External ready, active high |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse in the final cycle of an access |

## Verification
The hardest situation to reach from the ports is the global wait bit set to 1. Reaching it takes two ordered register writes: first the unlock bit, then the mode register. The effect is visible only through the lengths of later accesses. The bench keeps its own model of all three registers. It walks the wait bit and the fast bits through every value before sweeping all areas, bus modes and chip selects. It also tries mode writes with the unlock bit cleared, and issues stray register writes during a busy access to show that they are dropped.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    typedef enum logic [1:0] {
        AREA_SFR = 2'd0,
        AREA_INT = 2'd1,
        AREA_OSD = 2'd2,
        AREA_EXT = 2'd3
    } area_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_STRETCH = 2'd2
    } state_e;
endpackage

// File: rtl/bwc_ctrl_regs.sv
module bwc_ctrl_regs #(
    parameter int ADDR_W    = 16,
    parameter int NUM_CS    = 4,
    parameter int MODE_ADDR = 5,
    parameter int CSEL_ADDR = 8,
    parameter int PROT_ADDR = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wait_all,
    output logic [NUM_CS-1:0] fast_cs,
    output logic              unlock
);
    localparam int CS_LSB   = 4;
    localparam int WAIT_BIT = 7;
    localparam int PROT_BIT = 1;

    logic sel_mode, sel_csel, sel_prot;
    assign sel_mode = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
    assign sel_csel = wr_en && (wr_addr == ADDR_W'(CSEL_ADDR));
    assign sel_prot = wr_en && (wr_addr == ADDR_W'(PROT_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        unlock <= 1'b0;
        else if (sel_prot) unlock <= wr_data[PROT_BIT];
    end

    // Mode write is honoured only when unlock was already set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wait_all <= 1'b0;
        else if (sel_mode && unlock) wait_all <= wr_data[WAIT_BIT];
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        fast_cs[i] <= 1'b0;
            else if (sel_csel) fast_cs[i] <= wr_data[CS_LSB+i];
        end
    end
endmodule

// File: rtl/bwc_cycle_calc.sv
module bwc_cycle_calc
    import bwc_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int SFR_CYC  = 2,
    parameter int WAIT_CYC = 2,
    parameter int MUX_CYC  = 3
) (
    input  area_e            area,
    input  logic             mux_bus,
    input  logic             wait_all,
    input  logic             cs_fast,
    output logic [CNT_W-1:0] cycles
);
    always_comb begin
        unique case (area)
            AREA_SFR: cycles = CNT_W'(SFR_CYC);
            AREA_INT: cycles = wait_all ? CNT_W'(WAIT_CYC) : CNT_W'(1);
            AREA_OSD: cycles = CNT_W'(WAIT_CYC);
            AREA_EXT: begin
                if (mux_bus)                   cycles = CNT_W'(MUX_CYC);
                else if (!wait_all && cs_fast) cycles = CNT_W'(1);
                else                           cycles = CNT_W'(WAIT_CYC);
            end
            default:  cycles = CNT_W'(WAIT_CYC);
        endcase
    end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_CS    = 4,
    parameter int MODE_ADDR = 5,
    parameter int CSEL_ADDR = 8,
    parameter int PROT_ADDR = 10,
    parameter int SFR_CYC   = 2,
    parameter int WAIT_CYC  = 2,
    parameter int MUX_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    input  logic [1:0]        area,
    input  logic [1:0]        cs_idx,
    input  logic              mux_bus,
    input  logic              rdy,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = $clog2(MUX_CYC + 1);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             ext_q, ext_d;
    logic             accept;
    logic             wait_bit, unlock;
    logic [NUM_CS-1:0] fast_cs;
    logic [CNT_W-1:0] cycles;
    area_e            area_t;

    assign area_t = area_e'(area);
    assign accept = (state_q == ST_IDLE) && req;

    bwc_ctrl_regs #(
        .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .MODE_ADDR(MODE_ADDR),
        .CSEL_ADDR(CSEL_ADDR), .PROT_ADDR(PROT_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && we && (area_t == AREA_SFR)),
        .wr_addr(addr), .wr_data(wdata),
        .wait_all(wait_bit), .fast_cs(fast_cs), .unlock(unlock)
    );

    bwc_cycle_calc #(
        .CNT_W(CNT_W), .SFR_CYC(SFR_CYC), .WAIT_CYC(WAIT_CYC), .MUX_CYC(MUX_CYC)
    ) u_calc (
        .area(area_t), .mux_bus(mux_bus), .wait_all(wait_bit),
        .cs_fast(fast_cs[cs_idx]), .cycles(cycles)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            ext_q   <= ext_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        ext_d   = ext_q;
        unique case (state_q)
            ST_IDLE: if (req) begin
                state_d = ST_RUN;
                rem_d   = cycles - CNT_W'(1);
                ext_d   = (area_t == AREA_EXT);
            end
            ST_RUN: begin
                if (rem_q != '0)         rem_d   = rem_q - CNT_W'(1);
                else if (ext_q && !rdy)  state_d = ST_STRETCH;
                else                     state_d = ST_IDLE;
            end
            ST_STRETCH: if (rdy) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RUN: begin
                busy = 1'b1;
                done = (rem_q == '0) && (!ext_q || rdy);
            end
            ST_STRETCH: begin
                busy = 1'b1;
                done = rdy;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk #(
    parameter int ADDR_W    = 16,
    parameter int MODE_ADDR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [1:0]        area,
    input logic              busy,
    input logic              done,
    input logic              wait_bit,
    input logic              unlock
);
    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));
    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy);
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R2
    sfr_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && area == 2'd0) |=> (!done ##1 done));
    // R8
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && we && area == 2'd0 && addr == ADDR_W'(MODE_ADDR) && !unlock)
        |=> $stable(wait_bit));
endmodule

bind bus_wait_ctrl bwc_chk #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .area(area),
    .busy(busy), .done(done), .wait_bit(wait_bit), .unlock(unlock)
);

// File: tb/bus_wait_ctrl_bench.sv
module bus_wait_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, mux_bus = 1'b0, rdy = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [1:0]  area = '0, cs_idx = '0;
    logic        busy, done;

    int errors = 0, checks = 0;
    bit finished = 0;
    bit m_wait = 0, m_prot = 0;
    bit [3:0] m_cs = '0;

    bus_wait_ctrl u_bus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .wdata(wdata),
        .area(area), .cs_idx(cs_idx), .mux_bus(mux_bus), .rdy(rdy),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_cyc(int ar, bit mx, bit w, bit csb);
        case (ar)
            0: return 2;
            1: return w ? 2 : 1;
            2: return 2;
            default: return mx ? 3 : ((!w && csb) ? 1 : 2);
        endcase
    endfunction

    function automatic string tag_of(int ar, bit mx);
        case (ar)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return mx ? "R6" : "R5";
        endcase
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One access; k = cycles rdy stays low past the computed length
    task automatic access(int ar, int cs, bit mx, int k, bit wr,
                          logic [15:0] a, logic [7:0] d, string rq);
        int base, total, n;
        base  = exp_cyc(ar, mx, m_wait, m_cs[cs]);
        total = (ar == 3) ? base + k : base;
        @(negedge clk);
        req = 1; area = 2'(ar); cs_idx = 2'(cs); mux_bus = mx;
        we = wr; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
        if (wr && ar == 0) begin
            if (a == 16'h000A) m_prot = d[1];
            if (a == 16'h0008) m_cs = d[7:4];
            if (a == 16'h0005 && m_prot) m_wait = d[7];
        end
        n = 0;
        forever begin
            n++;
            rdy = (n >= base + k);
            if (n == 1 && total >= 2) begin
                // R11: stray write of unlock=0 during busy must be dropped
                req = 1; area = 2'd0; we = 1; addr = 16'h000A; wdata = 8'h00;
            end
            if (n == 2) req = 0;
            #1;
            if (done || n > 12) break;
            @(negedge clk);
        end
        req = 0;
        check(n == total, rq, n, total);
        @(negedge clk);
        rdy = 1;
        #1;
        check(!busy && !done, "R10/R11 idle after done", {busy, done}, 0);
    endtask

    task automatic set_mode(bit w);
        access(0, 0, 0, 0, 1, 16'h000A, 8'h02, "R7");
        access(0, 0, 0, 0, 1, 16'h0005, {w, 7'b0}, "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        if (!finished) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done, "R1 reset outputs", {busy, done}, 0);
        rst_n = 1;
        access(3, 0, 0, 0, 0, 0, 0, "R1 ext default");
        access(1, 0, 0, 0, 0, 0, 0, "R1 int default");
        // R8: locked mode write
        access(0, 0, 0, 0, 1, 16'h0005, 8'h80, "R8");
        access(1, 0, 0, 0, 0, 0, 0, "R8 wait still 0");
        // Exhaustive sweep
        for (int w = 0; w < 2; w++) begin
            for (int cb = 0; cb < 2; cb++) begin
                access(0, 0, 0, 0, 1, 16'h0008, cb ? 8'hF0 : 8'h00, "R7");
                set_mode(w[0]);
                for (int ar = 0; ar < 4; ar++)
                    for (int mx = 0; mx < 2; mx++)
                        for (int cs = 0; cs < 4; cs++)
                            access(ar, cs, mx[0], 0, 0, 0, 0, tag_of(ar, mx[0]));
            end
        end
        // R9: ready stretching, and ignored for non-external areas
        for (int k = 1; k < 4; k++) begin
            access(3, 1, 0, k, 0, 0, 0, "R9 sep");
            access(3, 2, 1, k, 0, 0, 0, "R9 mux");
            access(2, 0, 0, k, 0, 0, 0, "R9 osd ignores rdy");
        end
        // R8 after relocking
        set_mode(0);
        access(0, 0, 0, 0, 1, 16'h000A, 8'h00, "R7");
        access(0, 0, 0, 0, 1, 16'h0005, 8'h80, "R8");
        access(1, 0, 0, 0, 0, 0, 0, "R8 relock");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int sel, ar;
            sel = $urandom_range(0, 9);
            if (sel == 0)
                access(0, 0, 0, 0, 1, 16'h0008, 8'($urandom()), "R7 csel");
            else if (sel == 1)
                access(0, 0, 0, 0, 1, 16'h000A, 8'($urandom()), "R7 prot");
            else if (sel == 2)
                access(0, 0, 0, 0, 1, 16'h0005, 8'($urandom()), "R8 mode");
            else begin
                ar = $urandom_range(0, 3);
                access(ar, $urandom_range(0, 3), 1'($urandom()),
                       $urandom_range(0, 2), 0, 0, 0,
                       (ar == 3) ? "R9 random ext" : "R3 random");
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule